// File: doc/BRIEF.md
# Command-Sequenced Phase Sign Detector

This block watches two sampled clock-like inputs, a reference and a feedback divided clock. It records which of them showed a rising edge first. It reports only the sign of the phase error and never its size. It does not clear itself. An outside controller sequences it through four command inputs:

- an enable that opens the capture window;
- an active-low clear that returns the detector to its empty state;
- a get that copies the held polarity into two output flags;
- a judge that reports whether the held polarity is the opposite of the one last fetched.

Both inputs are sampled on the system clock. A rising edge is a sample of 1 that follows a sample of 0. The detector core is a three-state machine:

- `PS_IDLE`: no edge has been recorded.
- `PS_LEAD`: the reference edge came first, so the feedback lags and the loop should speed up.
- `PS_LAG`: the feedback edge came first.

The transitions are:

- *arm-lead*: `PS_IDLE` to `PS_LEAD`, taken on a reference rise while enabled, with or without a feedback rise in the same cycle.
- *arm-lag*: `PS_IDLE` to `PS_LAG`, taken on a feedback rise alone while enabled.
- *clear*: any state to `PS_IDLE`, taken while the clear command is low.

`PS_LEAD` and `PS_LAG` stay where they are until a clear. Once the state is armed, further edges on either input are ignored.

Top module: `phase_sign_detector`

## Requirements
- R1: When enabled in `PS_IDLE`, a reference rise with no feedback rise arms the lead polarity. A following get gives `flag_lead`=1 and `flag_lag`=0.
- R2: When enabled in `PS_IDLE`, a feedback rise with no reference rise arms the lag polarity. A following get gives `flag_lead`=0 and `flag_lag`=1.
- R3: Rises on both inputs in the same sampled cycle arm the lead polarity.
- R4: An armed polarity holds until a clear command. Later edges on either input, while enabled, do not change what a get returns.
- R5: While `cmd_clear_n` is 0 at a clock edge, the detector returns to `PS_IDLE`. A get in the next cycle returns both flags 0, and capture resumes once `cmd_clear_n` is 1 again.
- R6: Rising edges seen while `cmd_enable` is 0 are not recorded.
- R7: `flag_lead` and `flag_lag` change only at a clock edge where `cmd_get` is 1. They then take the held polarity one cycle after the get cycle.
- R8: At an edge with `cmd_judge` = 1, `flag_flip` becomes 1 if the held polarity is the opposite of the flags latched before that edge, and 0 otherwise. It keeps its value until the next judge.
- R9: While `rst_n` is 0, all three flags are 0 at once, independent of the clock.
- R10: `flag_lead` and `flag_lag` are never both 1.
- R11: An input that rose while capture was disabled and is still high when capture is enabled is not a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | asynchronous global reset, active low |
| ref_in | input | 1 | sampled reference clock |
| fb_in | input | 1 | sampled feedback divided clock |
| cmd_enable | input | 1 | capture window open |
| cmd_clear_n | input | 1 | detector clear command, active low |
| cmd_get | input | 1 | latch the held polarity into the flags |
| cmd_judge | input | 1 | compare the held polarity with the latched flags |
| flag_lead | output | 1 | latched: reference edge came first |
| flag_lag | output | 1 | latched: feedback edge came first |
| flag_flip | output | 1 | latched: polarity reversed at the last judge |

## Verification
An input rise driven in cycle k moves the state at the edge that ends cycle k. A get in cycle k+1 therefore shows its result on the flags after the edge that ends cycle k+1, and a judge follows the same one-edge rule. The bench drives every input at the falling edge and updates a behavioural model at the rising edge. It compares the model with the outputs at the next falling edge, so each result is read exactly one edge after its command. Directed checks are made one cycle after each get or judge. The asynchronous reset is checked one nanosecond after it falls.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_LEAD = 2'd1,
        PS_LAG  = 2'd2
    } pol_state_t;

    localparam int SRC_REF = 0;
    localparam int SRC_FB  = 1;
    localparam int NUM_SRC = 2;
endpackage

// File: rtl/ppd_edge.sv
module ppd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/ppd_fsm.sv
module ppd_fsm
    import ppd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_n,
    input  logic enable,
    input  logic rise_ref,
    input  logic rise_fb,
    output logic raw_up,
    output logic raw_dn
);
    pol_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!clear_n) begin
            state_d = PS_IDLE;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (enable && rise_ref)     state_d = PS_LEAD;
                    else if (enable && rise_fb) state_d = PS_LAG;
                end
                PS_LEAD: state_d = PS_LEAD;
                PS_LAG:  state_d = PS_LAG;
                default: state_d = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        raw_up = 1'b0;
        raw_dn = 1'b0;
        unique case (state_q)
            PS_IDLE: ;
            PS_LEAD: raw_up = 1'b1;
            PS_LAG:  raw_dn = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ppd_result.sv
module ppd_result (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_up,
    input  logic raw_dn,
    input  logic get,
    input  logic judge,
    output logic flag_lead,
    output logic flag_lag,
    output logic flag_flip
);
    logic reversed;

    assign reversed = (raw_up & flag_lag) | (raw_dn & flag_lead);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_lead <= 1'b0;
            flag_lag  <= 1'b0;
            flag_flip <= 1'b0;
        end else begin
            if (get) begin
                flag_lead <= raw_up;
                flag_lag  <= raw_dn;
            end
            if (judge) flag_flip <= reversed;
        end
    end
endmodule

// File: rtl/phase_sign_detector.sv
module phase_sign_detector
    import ppd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic cmd_enable,
    input  logic cmd_clear_n,
    input  logic cmd_get,
    input  logic cmd_judge,
    output logic flag_lead,
    output logic flag_lag,
    output logic flag_flip
);
    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] rise_vec;
    logic raw_up, raw_dn;

    assign src_vec[SRC_REF] = ref_in;
    assign src_vec[SRC_FB]  = fb_in;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
        ppd_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (src_vec[g]),
            .rise   (rise_vec[g])
        );
    end

    ppd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_n  (cmd_clear_n),
        .enable   (cmd_enable),
        .rise_ref (rise_vec[SRC_REF]),
        .rise_fb  (rise_vec[SRC_FB]),
        .raw_up   (raw_up),
        .raw_dn   (raw_dn)
    );

    ppd_result u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_up    (raw_up),
        .raw_dn    (raw_dn),
        .get       (cmd_get),
        .judge     (cmd_judge),
        .flag_lead (flag_lead),
        .flag_lag  (flag_lag),
        .flag_flip (flag_flip)
    );
endmodule

// File: rtl/ppd_checker.sv
module ppd_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_clear_n,
    input logic cmd_get,
    input logic cmd_judge,
    input logic raw_up,
    input logic raw_dn,
    input logic flag_lead,
    input logic flag_lag,
    input logic flag_flip
);
    // R10
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_lead, flag_lag}));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_get |=> $stable({flag_lead, flag_lag}));

    // R8
    flip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_judge |=> $stable(flag_flip));

    // R4
    lead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_up && cmd_clear_n) |=> raw_up);

    // R4
    lag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_dn && cmd_clear_n) |=> raw_dn);

    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_clear_n ##1 cmd_get) |=> (!flag_lead && !flag_lag));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!flag_lead && !flag_lag && !flag_flip));
endmodule

bind phase_sign_detector ppd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_clear_n (cmd_clear_n),
    .cmd_get     (cmd_get),
    .cmd_judge   (cmd_judge),
    .raw_up      (raw_up),
    .raw_dn      (raw_dn),
    .flag_lead   (flag_lead),
    .flag_lag    (flag_lag),
    .flag_flip   (flag_flip)
);

// File: tb/tb_phase_sign_detector.sv
`timescale 1ns/1ps
module tb_phase_sign_detector;
    logic clk = 1'b0;
    logic rst_n;
    logic ref_in = 1'b0, fb_in = 1'b0;
    logic cmd_enable = 1'b0, cmd_clear_n = 1'b1, cmd_get = 1'b0, cmd_judge = 1'b0;
    logic flag_lead, flag_lag, flag_flip;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural model: 0 = none, 1 = lead, 2 = lag
    int m_pol = 0;
    bit m_prev_ref = 0, m_prev_fb = 0;
    bit m_lead = 0, m_lag = 0, m_flip = 0;

    always #2.5 clk = ~clk;

    phase_sign_detector dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .cmd_enable(cmd_enable), .cmd_clear_n(cmd_clear_n),
        .cmd_get(cmd_get), .cmd_judge(cmd_judge),
        .flag_lead(flag_lead), .flag_lag(flag_lag), .flag_flip(flag_flip)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = 0; m_prev_ref = 0; m_prev_fb = 0;
            m_lead = 0; m_lag = 0; m_flip = 0;
        end else begin
            bit r_rise, f_rise;
            int pol_now;
            r_rise = ref_in && !m_prev_ref;
            f_rise = fb_in && !m_prev_fb;
            pol_now = m_pol;
            if (cmd_judge) m_flip = (pol_now == 1 && m_lag) || (pol_now == 2 && m_lead);
            if (cmd_get) begin
                m_lead = (pol_now == 1);
                m_lag  = (pol_now == 2);
            end
            if (!cmd_clear_n) m_pol = 0;
            else if (cmd_enable && m_pol == 0) begin
                if (r_rise) m_pol = 1;
                else if (f_rise) m_pol = 2;
            end
            m_prev_ref = ref_in;
            m_prev_fb  = fb_in;
        end
    end

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        check_bit("R7 lead", flag_lead, m_lead);
        check_bit("R7 lag", flag_lag, m_lag);
        check_bit("R8 flip", flag_flip, m_flip);
        check_bit("R10 both", flag_lead & flag_lag, 1'b0);
    endtask

    task automatic step(logic r, logic f, logic en, logic g, logic c, logic j);
        @(negedge clk);
        compare_model();
        ref_in = r; fb_in = f; cmd_enable = en; cmd_get = g; cmd_clear_n = c; cmd_judge = j;
    endtask

    task automatic idle();
        step(ref_in, fb_in, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic expect_flags(string tag, logic l, logic d, logic fl);
        check_bit({tag, " lead"}, flag_lead, l);
        check_bit({tag, " lag"}, flag_lag, d);
        check_bit({tag, " flip"}, flag_flip, fl);
    endtask

    task automatic do_clear();
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_get();
        step(0, 0, 0, 1, 1, 0);
        idle();
    endtask

    task automatic do_judge();
        step(0, 0, 0, 0, 1, 1);
        idle();
    endtask

    initial begin
        #20000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        expect_flags("R9", 0, 0, 0);
        rst_n = 1'b1;
        do_clear();

        // R1 reference first
        step(1, 0, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        step(0, 1, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        do_get();
        expect_flags("R1", 1, 0, 0);

        // R8 judge with same polarity
        do_judge();
        expect_flags("R8 same", 1, 0, 0);

        // R4 later edges ignored
        step(0, 1, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        do_get();
        expect_flags("R4", 1, 0, 0);

        // R5 clear empties the detector
        do_clear();
        do_get();
        expect_flags("R5", 0, 0, 0);

        // R5 capture resumes after clear; latch lead
        step(1, 0, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        do_get();
        expect_flags("R5 resume", 1, 0, 0);

        // R2 feedback first; R8 judge sees reversal before get (R7 flags unchanged)
        do_clear();
        step(0, 1, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        do_judge();
        expect_flags("R8 flip", 1, 0, 1);
        check_bit("R7 no get", flag_lead, 1'b1);
        do_get();
        expect_flags("R2", 0, 1, 1);
        do_judge();
        expect_flags("R8 clear", 0, 1, 0);

        // R6 edges while disabled
        do_clear();
        step(1, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 0);
        step(0, 1, 0, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        do_get();
        expect_flags("R6", 0, 0, 0);

        // R11 level held from disabled window is not an edge
        do_clear();
        step(1, 0, 0, 0, 1, 0);
        step(1, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 1, 0);
        step(1, 1, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        do_get();
        expect_flags("R11", 0, 1, 0);

        // R3 simultaneous rises
        do_clear();
        step(1, 1, 1, 0, 1, 0);
        step(0, 0, 1, 0, 1, 0);
        do_get();
        expect_flags("R3", 1, 0, 0);

        // mixed patterns compared against the model every cycle
        for (int i = 0; i < 60; i++) begin
            step(i[0] ^ i[3], i[1] ^ i[4], i[2] | i[5], (i % 5) == 4, (i % 7) != 6, (i % 6) == 3);
        end

        // R9 asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        expect_flags("R9 async", 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        ref_in = 0; fb_in = 0; cmd_enable = 0; cmd_get = 0; cmd_judge = 0; cmd_clear_n = 1;
        do_get();
        expect_flags("R9 after", 0, 0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule